// File: doc/BRIEF.md
# Host Strobe-Handshake Memory and Register Port

This block is the synchronous slave port through which an external 16-bit processor reaches a shared RAM and a small register file. The processor opens a cycle by pulling a strobe low. A chip select qualifies the cycle. A memory/register select line picks the RAM or the register file, and a direction line picks read or write. The port answers with an active-low enable (`ioen_n`) once it owns the storage. It then gives an active-low ready (`rdy_n`) a fixed number of cycles later. Raising the strobe ends the cycle.

The same storage is used by an internal protocol engine. That engine asks for access on a request/grant pair. A processor cycle that collides with an engine access waits until the engine is done. A processor cycle that has already started is never cut short: the engine waits until the strobe releases it.

The port latches its inputs at two points. Address and write data follow the pins until the first rising clock edge after the enable falls. The two control lines follow the pins until the first falling edge after the enable falls. The storage itself sits outside the block on a simple word port.

Top module: `hp_port_top`

## Requirements
- R1: `ioen_n` goes low just after the second consecutive rising edge that samples `strb_n` low, if `sel_n` is also low on that edge and the engine grant is low. One sample of the strobe low is not enough.
- R2: If `sel_n` is high on that second edge, no transfer happens, even if `sel_n` falls later. `ioen_n` stays high until the strobe has been sampled high again.
- R3: If the engine grant is high on that second edge, the transfer is deferred. `ioen_n` falls on the edge after the one at which the grant drops.
- R4: `eng_gnt` rises on the edge after `eng_req` is seen, while the processor does not own the storage. It is never high while `ioen_n` is low. When the engine request and the processor's second strobe edge coincide, the processor wins. When the strobe releases the port, a waiting request is granted on that same edge.
- R5: `rdy_n` falls exactly RDY_LAT (default 3) rising edges after `ioen_n` falls. Both return high on the edge that samples `strb_n` high.
- R6: `mem_sel` = 1 selects RAM, with storage address equal to the low 14 address bits. `mem_sel` = 0 selects a register. Its storage address is the low 5 address bits, and storage address bits 13..5 are zero.
- R7: With `rw_pol` = 1, `rd_wr` = 1 means read. With `rw_pol` = 0 the sense flips, and `rd_wr` = 0 means read.
- R8: `addr` and `wdata` are taken from the pins up to the first rising edge after `ioen_n` falls. Changes after that edge have no effect on the transfer.
- R9: `mem_sel` and `rd_wr` are taken from the pins up to the first falling edge after `ioen_n` falls. Changes after that edge have no effect on the transfer.
- R10: A write stores the latched data with a single one-cycle `st_we` pulse that ends at the edge where `rdy_n` falls. A read shows the selected word on `rdata` while `rdy_n` is low. `rdata` is zero at all other times.
- R11: While the strobe stays low after ready, no new transfer starts and `ioen_n` and `rdy_n` stay low. After the strobe has been seen high, a new transfer again needs two fresh low samples.
- R12: During and after reset, `ioen_n` and `rdy_n` are high, and `eng_gnt`, `st_we` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strb_n | input | 1 | Host strobe, active low |
| sel_n | input | 1 | Host chip select, active low |
| mem_sel | input | 1 | 1 = RAM access, 0 = register access |
| rd_wr | input | 1 | Direction line, sense set by `rw_pol` |
| rw_pol | input | 1 | 1: `rd_wr` high reads; 0: `rd_wr` low reads |
| addr | input | 14 | Host word address |
| wdata | input | 16 | Host write data |
| ioen_n | output | 1 | Transfer enable, active low |
| rdy_n | output | 1 | Transfer ready, active low |
| rdata | output | 16 | Read data, valid while `rdy_n` is low |
| eng_req | input | 1 | Engine storage request |
| eng_gnt | output | 1 | Engine storage grant |
| st_ram | output | 1 | Storage select: 1 RAM, 0 register file |
| st_addr | output | 14 | Storage word address |
| st_we | output | 1 | Storage write strobe |
| st_wdata | output | 16 | Storage write data |
| st_rdata | input | 16 | Storage read data, combinational from `st_ram`/`st_addr` |

## Verification
A wrong handshake state shows up at once, on the edge it occurs, as `ioen_n` or `rdy_n` in the wrong level. Examples are an enable one edge early, a ready that comes RDY_LAT edges late, or an enable that stays low after the strobe is seen high. A broken arbitration state shows as `eng_gnt` high in a cycle where `ioen_n` is low. Latching faults are quieter. A capture taken on the wrong edge only appears when a later read returns a word at an unexpected address or with unexpected data. For that reason the bench changes the pins on either side of each latch point and reads every write back.

// File: rtl/hp_pkg.sv
package hp_pkg;

  // Handshake sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for a first low strobe sample
    ST_LOW1  = 3'd1,  // one low sample seen
    ST_WAIT  = 3'd2,  // selected, deferred behind the engine
    ST_XFER  = 3'd3,  // enable low, counting to ready
    ST_READY = 3'd4,  // ready low, waiting for strobe release
    ST_SKIP  = 3'd5   // not selected, waiting for strobe release
  } hp_state_e;

endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int RDY_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  input  logic sel_n,
  input  logic eng_busy,
  output logic ioen_n,
  output logic rdy_n,
  output logic commit,
  output logic own_next
);

  localparam int CW = $clog2(RDY_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(RDY_LAT - 1);

  hp_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!strb_n) st_d = ST_LOW1;
      ST_LOW1: begin
        if (strb_n)        st_d = ST_IDLE;
        else if (sel_n)    st_d = ST_SKIP;
        else if (eng_busy) st_d = ST_WAIT;
        else begin
          st_d   = ST_XFER;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (strb_n) st_d = ST_IDLE;
        else if (!eng_busy) begin
          st_d   = ST_XFER;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_XFER: begin
        if (strb_n)             st_d = ST_IDLE;
        else if (cnt_q == LAST) st_d = ST_READY;
        else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_READY: if (strb_n) st_d = ST_IDLE;
      ST_SKIP:  if (strb_n) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ioen_n   = !(st_q == ST_XFER || st_q == ST_READY);
  assign rdy_n    = !(st_q == ST_READY);
  assign commit   = (st_q == ST_XFER) && !strb_n && (cnt_q == LAST);
  assign own_next = (st_d == ST_XFER) || (st_d == ST_READY);

  // R1
  ioen_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ioen_n) |-> !$past(strb_n));

  // R5
  ready_inside_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> !ioen_n);

  // R5
  release_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_n && !ioen_n) |=> (ioen_n && rdy_n));

endmodule

// File: rtl/hp_arb.sv
module hp_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_req,
  input  logic cpu_own_next,
  output logic eng_gnt
);

  logic gnt_d;

  always_comb gnt_d = eng_req && !cpu_own_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_gnt <= 1'b0;
    else        eng_gnt <= gnt_d;
  end

  // R4
  grant_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gnt |-> $past(eng_req));

endmodule

// File: rtl/hp_capture.sv
module hp_capture #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ioen_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          mem_in,
  input  logic          rw_in,
  output logic [AW-1:0] addr_eff,
  output logic [DW-1:0] data_eff,
  output logic          mem_eff,
  output logic          rw_eff
);

  logic          a_lock_q, a_lock_d, a_cap;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          c_lock_q, c_lock_d, c_cap;
  logic          mem_q, rw_q;

  always_comb begin
    a_lock_d = !ioen_n;
    a_cap    = !ioen_n && !a_lock_q;
    c_lock_d = !ioen_n;
    c_cap    = !ioen_n && !c_lock_q;
  end

  // address and data: first rising edge after the enable falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lock_q <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
    end else begin
      a_lock_q <= a_lock_d;
      if (a_cap) begin
        a_q <= addr_in;
        d_q <= data_in;
      end
    end
  end

  // control lines: first falling edge after the enable falls
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_lock_q <= 1'b0;
      mem_q    <= 1'b0;
      rw_q     <= 1'b0;
    end else begin
      c_lock_q <= c_lock_d;
      if (c_cap) begin
        mem_q <= mem_in;
        rw_q  <= rw_in;
      end
    end
  end

  assign addr_eff = a_lock_q ? a_q   : addr_in;
  assign data_eff = a_lock_q ? d_q   : data_in;
  assign mem_eff  = c_lock_q ? mem_q : mem_in;
  assign rw_eff   = c_lock_q ? rw_q  : rw_in;

  // R8
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_lock_q && $past(a_lock_q)) |-> ($stable(addr_eff) && $stable(data_eff)));

  // R9
  ctl_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lock_q && $past(c_lock_q)) |-> ($stable(mem_eff) && $stable(rw_eff)));

endmodule

// File: rtl/hp_port_top.sv
module hp_port_top #(
  parameter int RAM_AW  = 14,
  parameter int REG_AW  = 5,
  parameter int DW      = 16,
  parameter int RDY_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_n,
  input  logic              sel_n,
  input  logic              mem_sel,
  input  logic              rd_wr,
  input  logic              rw_pol,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              ioen_n,
  output logic              rdy_n,
  output logic [DW-1:0]     rdata,
  input  logic              eng_req,
  output logic              eng_gnt,
  output logic              st_ram,
  output logic [RAM_AW-1:0] st_addr,
  output logic              st_we,
  output logic [DW-1:0]     st_wdata,
  input  logic [DW-1:0]     st_rdata
);

  localparam int PAD = RAM_AW - REG_AW;

  logic [1:0]        rs_q;
  logic              rst_i;
  logic              commit, own_next;
  logic [RAM_AW-1:0] addr_eff;
  logic              mem_eff, rw_eff, is_read;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              rcap;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  hp_ctrl #(.RDY_LAT(RDY_LAT)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .strb_n   (strb_n),
    .sel_n    (sel_n),
    .eng_busy (eng_gnt),
    .ioen_n   (ioen_n),
    .rdy_n    (rdy_n),
    .commit   (commit),
    .own_next (own_next)
  );

  hp_arb i_arb (
    .clk          (clk),
    .rst_n        (rst_i),
    .eng_req      (eng_req),
    .cpu_own_next (own_next),
    .eng_gnt      (eng_gnt)
  );

  hp_capture #(.AW(RAM_AW), .DW(DW)) i_cap (
    .clk      (clk),
    .rst_n    (rst_i),
    .ioen_n   (ioen_n),
    .addr_in  (addr),
    .data_in  (wdata),
    .mem_in   (mem_sel),
    .rw_in    (rd_wr),
    .addr_eff (addr_eff),
    .data_eff (st_wdata),
    .mem_eff  (mem_eff),
    .rw_eff   (rw_eff)
  );

  always_comb begin
    is_read = rw_pol ? rw_eff : !rw_eff;
    st_ram  = mem_eff;
    st_addr = mem_eff ? addr_eff : {{PAD{1'b0}}, addr_eff[REG_AW-1:0]};
    st_we   = commit && !is_read;
    rcap    = commit;
    rdata_d = is_read ? st_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rdata_q <= '0;
    else if (rcap) rdata_q <= rdata_d;
  end

  assign rdata = rdy_n ? '0 : rdata_q;

  // R4
  exclusive_owner_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !(eng_gnt && !ioen_n));

  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_i)
    st_we |=> (!st_we && !rdy_n));

  // R10
  write_under_enable_chk: assert property (@(posedge clk) disable iff (!rst_i)
    st_we |-> (!ioen_n && rdy_n));

endmodule

// File: tb/test_hp_port_top.sv
`timescale 1ns/1ps
module test_hp_port_top;

  logic clk = 1'b0;
  logic rst_n, strb_n, sel_n, mem_sel, rd_wr, rw_pol, eng_req;
  logic [13:0] addr;
  logic [15:0] wdata;
  logic ioen_n, rdy_n, eng_gnt, st_ram, st_we;
  logic [15:0] rdata, st_wdata, st_rdata;
  logic [13:0] st_addr;

  logic [15:0] ram [256];
  logic [15:0] regs [32];

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hp_port_top i_hp_port_top (
    .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .sel_n(sel_n),
    .mem_sel(mem_sel), .rd_wr(rd_wr), .rw_pol(rw_pol), .addr(addr),
    .wdata(wdata), .ioen_n(ioen_n), .rdy_n(rdy_n), .rdata(rdata),
    .eng_req(eng_req), .eng_gnt(eng_gnt), .st_ram(st_ram),
    .st_addr(st_addr), .st_we(st_we), .st_wdata(st_wdata),
    .st_rdata(st_rdata)
  );

  // storage model
  assign st_rdata = st_ram ? ram[st_addr[7:0]] : regs[st_addr[4:0]];
  always @(posedge clk) begin
    if (st_we) begin
      if (st_ram) ram[st_addr[7:0]] <= st_wdata;
      else        regs[st_addr[4:0]] <= st_wdata;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // {mem, read, pol, addr14, wdata16, exp16}
  localparam int NV = 9;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 14'h0005, 16'hA5A5, 16'h0000},
    {1'b0, 1'b0, 1'b0, 14'h0003, 16'h1234, 16'h0000},
    {1'b1, 1'b1, 1'b0, 14'h0005, 16'h0000, 16'hA5A5},
    {1'b0, 1'b1, 1'b1, 14'h3FE3, 16'h0000, 16'h1234},
    {1'b1, 1'b0, 1'b1, 14'h00FF, 16'hFFFF, 16'h0000},
    {1'b1, 1'b1, 1'b1, 14'h00FF, 16'h0000, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 14'h001F, 16'h0F0F, 16'h0000},
    {1'b0, 1'b1, 1'b0, 14'h003F, 16'h0000, 16'h0F0F},
    {1'b1, 1'b1, 1'b1, 14'h0003, 16'h0000, 16'h0000}
  };

  // mode 0 plain, 1 address/data perturbation, 2 control perturbation
  task automatic xfer(input bit m, input bit rd, input bit pol,
                      input logic [13:0] a, input logic [15:0] d,
                      input logic [15:0] exp, input int mode);
    strb_n = 1'b0; sel_n = 1'b0; mem_sel = m; rw_pol = pol;
    rd_wr = pol ? rd : !rd; addr = a; wdata = d;
    step();
    chk(ioen_n == 1'b1, "R1 one low sample", ioen_n, 1);
    step();
    chk(ioen_n == 1'b0, "R1 enable on second edge", ioen_n, 0);
    if (mode == 1) begin addr = a + 14'd1; wdata = ~d; end
    if (mode == 2) begin mem_sel = !mem_sel; rd_wr = !rd_wr; end
    step();
    chk(rdy_n == 1'b1, "R5 ready not yet", rdy_n, 1);
    if (mode == 1) begin addr = a + 14'd2; wdata = 16'h5A5A; end
    if (mode == 2) begin mem_sel = !mem_sel; rd_wr = !rd_wr; end
    step();
    chk(rdy_n == 1'b1, "R5 ready not yet", rdy_n, 1);
    chk(rdata == 16'h0, "R10 rdata zero before ready", rdata, 0);
    step();
    chk(rdy_n == 1'b0, "R5 ready after latency", rdy_n, 0);
    if (mode == 0 && !m)
      chk(st_addr[13:5] == 9'h0, "R6 register address upper bits", st_addr, {9'h0, a[4:0]});
    if (mode == 0 && rd)
      chk(rdata == exp, "R10 R6 R7 read data", rdata, exp);
    strb_n = 1'b1; sel_n = 1'b1;
    step();
    chk(ioen_n && rdy_n, "R5 release", {ioen_n, rdy_n}, 2'b11);
    chk(rdata == 16'h0, "R10 rdata zero after", rdata, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0;
    for (int i = 0; i < 32; i++) regs[i] = 16'h0;
    rst_n = 1'b0; strb_n = 1'b1; sel_n = 1'b1; mem_sel = 1'b0; rd_wr = 1'b0;
    rw_pol = 1'b1; eng_req = 1'b0; addr = '0; wdata = '0;
    step(); step();
    // R12
    chk(ioen_n && rdy_n, "R12 reset handshake", {ioen_n, rdy_n}, 2'b11);
    chk(!eng_gnt && !st_we, "R12 reset grant/write", {eng_gnt, st_we}, 0);
    chk(rdata == 16'h0, "R12 reset rdata", rdata, 0);
    rst_n = 1'b1;
    step(); step(); step();

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      xfer(v[48], v[47], v[46], v[45:32], v[31:16], v[15:0], 0);
    end

    // R2: not selected on the second edge
    strb_n = 1'b0; sel_n = 1'b1;
    step(); step();
    chk(ioen_n == 1'b1, "R2 unselected", ioen_n, 1);
    sel_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(ioen_n == 1'b1, "R2 late select ignored", ioen_n, 1);
    end
    strb_n = 1'b1; sel_n = 1'b1;
    step();

    // R3 / R4: deferral behind the engine
    eng_req = 1'b1;
    step();
    chk(eng_gnt == 1'b1, "R4 engine granted", eng_gnt, 1);
    strb_n = 1'b0; sel_n = 1'b0; mem_sel = 1'b1; rw_pol = 1'b1; rd_wr = 1'b0;
    addr = 14'h0030; wdata = 16'h7777;
    step(); step();
    chk(ioen_n == 1'b1, "R3 deferred", ioen_n, 1);
    step();
    chk(ioen_n == 1'b1, "R3 still deferred", ioen_n, 1);
    eng_req = 1'b0;
    step();
    chk(!eng_gnt && ioen_n, "R3 grant drops first", {eng_gnt, ioen_n}, 2'b01);
    step();
    chk(ioen_n == 1'b0, "R3 starts after engine", ioen_n, 0);
    eng_req = 1'b1;
    step();
    chk(eng_gnt == 1'b0, "R4 engine waits", eng_gnt, 0);
    step(); step();
    chk(!rdy_n && !eng_gnt, "R4 engine waits at ready", {rdy_n, eng_gnt}, 0);
    strb_n = 1'b1; sel_n = 1'b1;
    step();
    chk(ioen_n && eng_gnt, "R4 grant at release", {ioen_n, eng_gnt}, 2'b11);
    eng_req = 1'b0;
    step();
    xfer(1'b1, 1'b1, 1'b1, 14'h0030, 16'h0, 16'h7777, 0);

    // R4 tie: processor second edge with a new engine request
    strb_n = 1'b0; sel_n = 1'b0; mem_sel = 1'b1; rd_wr = 1'b1; rw_pol = 1'b1;
    step();
    eng_req = 1'b1;
    step();
    chk(!ioen_n && !eng_gnt, "R4 tie to processor", {ioen_n, eng_gnt}, 2'b00);
    strb_n = 1'b1; sel_n = 1'b1;
    step();
    chk(eng_gnt == 1'b1, "R4 grant after abort", eng_gnt, 1);
    eng_req = 1'b0;
    step();

    // R8: address/data latch point
    xfer(1'b1, 1'b0, 1'b1, 14'h0010, 16'h1111, 16'h0, 1);
    xfer(1'b1, 1'b1, 1'b1, 14'h0011, 16'h0, 16'hEEEE, 0);
    xfer(1'b1, 1'b1, 1'b1, 14'h0012, 16'h0, 16'h0000, 0);
    xfer(1'b1, 1'b1, 1'b1, 14'h0010, 16'h0, 16'h0000, 0);

    // R9: control latch point (starts as register read, becomes RAM write)
    xfer(1'b0, 1'b1, 1'b1, 14'h0020, 16'h4444, 16'h0, 2);
    xfer(1'b1, 1'b1, 1'b0, 14'h0020, 16'h0, 16'h4444, 0);
    xfer(1'b0, 1'b1, 1'b1, 14'h0000, 16'h0, 16'h0000, 0);

    // R11: strobe held low after ready, then a fresh transfer
    strb_n = 1'b0; sel_n = 1'b0; mem_sel = 1'b1; rw_pol = 1'b1; rd_wr = 1'b1;
    addr = 14'h0005;
    for (int k = 0; k < 5; k++) step();
    for (int k = 0; k < 5; k++) begin
      chk(!ioen_n && !rdy_n, "R11 held low", {ioen_n, rdy_n}, 0);
      step();
    end
    chk(rdata == 16'hA5A5, "R11 read held", rdata, 16'hA5A5);
    strb_n = 1'b1;
    step();
    chk(ioen_n == 1'b1, "R11 released", ioen_n, 1);
    strb_n = 1'b0;
    step();
    chk(ioen_n == 1'b1, "R11 needs two samples", ioen_n, 1);
    step();
    chk(ioen_n == 1'b0, "R11 restart", ioen_n, 0);
    strb_n = 1'b1; sel_n = 1'b1;
    step(); step();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule